// File: doc/BRIEF.md
# Prioritised Interrupt Pending Controller

This block collects up to 32 interrupt requests and presents them to a processor, one at a time. Each request line records an event in a source-pending register. A per-source mask keeps a recorded event away from the processor. A fixed-priority arbiter copies one unmasked pending source into a second, single-bit pending register. The `irq_o` output stays high while that register holds a bit.

A routing register can send exactly one source to the fast output `fiq_o`. That source then bypasses arbitration. Software clears events by writing ones to either pending register, and it reads the number of the source that won arbitration from an index register.

The register bus is synchronous. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. Request inputs are assumed to be synchronous to `clk`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both pending registers and the routing register read 0, the mask reads all ones, and `irq_o` and `fiq_o` are low.
- R2: Source positions 6 and 24 are reserved. Their pending bits never set, whatever their request inputs do.
- R3: An edge-type source sets its pending bit on a 0-to-1 transition of its request. The bit is held until software clears it. A request that stays high does not set the bit again after a clear.
- R4: A level-type source sets its pending bit on every clock edge where its request is high. A clear issued while the request is still high leaves the bit set. In the default configuration the level-type sources are 4, 5, 15, 23, 28 and 31.
- R5: Writing to the source-pending register (offset 0x00) or the arbitrated-pending register (offset 0x10) clears each bit written as 1. Bits written as 0 are left unchanged.
- R6: The mask register (offset 0x08, read/write) disables a source when its bit is 1. A masked source still records its pending bit, but it reaches neither the arbiter nor `fiq_o`.
- R7: When the arbitrated-pending register is empty, it loads, on the next edge, a one-hot copy of the lowest-numbered source that is pending, unmasked and not routed to `fiq_o`. While the register is non-empty it keeps its value until software clears it.
- R8: `irq_o` is high exactly while the arbitrated-pending register is non-zero. Offset 0x14 reads the bit number held in that register, and reads 0 when it is empty.
- R9: The routing register (offset 0x04) keeps only the lowest set bit of a written value. The routed source, when pending and unmasked, drives `fiq_o` high and is never arbitrated. Writing 0 removes the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_req | input | 32 | Request lines, one per source |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
The bench sweeps every source position on its own and checks recording, arbitration, the index value and clearing. This catches a wrong edge/level table or a broken reserved position: such a design would report a bit that should stay silent, or miss one that should set. Simultaneous requests show whether the arbiter picks the lowest number and reloads only after a clear; a design that reloaded while the register was occupied would change the reported source mid-service. Held requests separate edge from level behaviour, so a re-set edge source or a non-re-set level source shows up. Zero writes, multi-bit routing writes and routing removal expose designs that clear on 0, that keep several routed sources, or that leave a source stranded on the fast output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam logic [7:0] OFS_SRC_PEND = 8'h00;
  localparam logic [7:0] OFS_ROUTE    = 8'h04;
  localparam logic [7:0] OFS_MASK     = 8'h08;
  localparam logic [7:0] OFS_ARB_PEND = 8'h10;
  localparam logic [7:0] OFS_ARB_IDX  = 8'h14;

  typedef enum logic [2:0] {
    SEL_SRC,
    SEL_ROUTE,
    SEL_MASK,
    SEL_ARB,
    SEL_IDX,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_SRC_PEND: decode_ofs = SEL_SRC;
      OFS_ROUTE:    decode_ofs = SEL_ROUTE;
      OFS_MASK:     decode_ofs = SEL_MASK;
      OFS_ARB_PEND: decode_ofs = SEL_ARB;
      OFS_ARB_IDX:  decode_ofs = SEL_IDX;
      default:      decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqc_src_capture.sv
module irqc_src_capture #(
  parameter int unsigned     NSRC       = 32,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0,
  parameter logic [NSRC-1:0] RSVD_MASK  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);

  localparam logic [NSRC-1:0] EDGE_SET  = ~LEVEL_MASK & ~RSVD_MASK;
  localparam logic [NSRC-1:0] LEVEL_SET = LEVEL_MASK & ~RSVD_MASK;

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] set_ev;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      if (RSVD_MASK[gi]) begin : g_rsvd
        assign set_ev[gi] = 1'b0;
      end else if (LEVEL_MASK[gi]) begin : g_level
        assign set_ev[gi] = req[gi];
      end else begin : g_edge
        assign set_ev[gi] = req[gi] & ~req_q[gi];
      end
    end
  endgenerate

  // new events win over a clear on the same edge
  always_comb begin
    pend_d = (pend_q & ~clr) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  assert_rsvd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & RSVD_MASK) == '0));

  assert_edge_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q & ~$past(pend_q) & EDGE_SET) &
               ~($past(req) & ~$past(req_q))) == '0));

  assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & LEVEL_SET) != '0) |=> ((pend_q & $past(req & LEVEL_SET)) == $past(req & LEVEL_SET)));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  cand,
  input  logic [NSRC-1:0]  clr,
  output logic [NSRC-1:0]  arb,
  output logic [IDX_W-1:0] idx
);

  logic [NSRC-1:0] arb_q;
  logic [NSRC-1:0] arb_d;
  logic [NSRC-1:0] lowest;
  logic            arb_empty;

  assign arb_empty = (arb_q == '0);
  assign lowest    = cand & (~cand + NSRC'(1));

  always_comb begin
    if (arb_empty) arb_d = lowest;
    else           arb_d = arb_q & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arb_q <= '0;
    else        arb_q <= arb_d;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (arb_q[i]) idx = IDX_W'(i);
    end
  end

  assign arb = arb_q;

  assert_arb_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_q));

  assert_arb_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_empty && cand != '0) |=> (arb_q != '0));

  assert_arb_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_empty && cand != '0) |=> (((arb_q - NSRC'(1)) & $past(cand)) == '0));

  assert_arb_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_empty && clr == '0) |=> $stable(arb_q));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned     NSRC       = 32,
  parameter int unsigned     ADDR_W     = 8,
  parameter logic [NSRC-1:0] LEVEL_MASK = 32'h9080_8030,
  parameter logic [NSRC-1:0] RSVD_MASK  = 32'h0100_0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   irq_req,
  output logic              irq_o,
  output logic              fiq_o
);
  import irqc_pkg::*;

  localparam int unsigned IDX_W = $clog2(NSRC);

  reg_sel_e        sel;
  logic [NSRC-1:0] src_pend;
  logic [NSRC-1:0] src_clr;
  logic [NSRC-1:0] arb_clr;
  logic [NSRC-1:0] arb_pend;
  logic [IDX_W-1:0] arb_idx;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] route_q, route_d;
  logic            mask_en, route_en;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] cand;

  assign sel = decode_ofs(8'(bus_addr));

  always_comb begin
    src_clr  = (bus_we && sel == SEL_SRC) ? bus_wdata : '0;
    arb_clr  = (bus_we && sel == SEL_ARB) ? bus_wdata : '0;
    mask_en  = bus_we && (sel == SEL_MASK);
    route_en = bus_we && (sel == SEL_ROUTE);
    mask_d   = bus_wdata;
    route_d  = bus_wdata & (~bus_wdata + NSRC'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      route_q <= '0;
    end else begin
      if (mask_en)  mask_q  <= mask_d;
      if (route_en) route_q <= route_d;
    end
  end

  irqc_src_capture #(
    .NSRC       (NSRC),
    .LEVEL_MASK (LEVEL_MASK),
    .RSVD_MASK  (RSVD_MASK)
  ) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_req),
    .clr   (src_clr),
    .pend  (src_pend)
  );

  assign live = src_pend & ~mask_q;
  assign cand = live & ~route_q;

  irqc_arbiter #(
    .NSRC  (NSRC),
    .IDX_W (IDX_W)
  ) u_arbiter (
    .clk   (clk),
    .rst_n (rst_n),
    .cand  (cand),
    .clr   (arb_clr),
    .arb   (arb_pend),
    .idx   (arb_idx)
  );

  assign irq_o = |arb_pend;
  assign fiq_o = |(live & route_q);

  always_comb begin
    case (sel)
      SEL_SRC:   bus_rdata = src_pend;
      SEL_ROUTE: bus_rdata = route_q;
      SEL_MASK:  bus_rdata = mask_q;
      SEL_ARB:   bus_rdata = arb_pend;
      SEL_IDX:   bus_rdata = NSRC'(arb_idx);
      default:   bus_rdata = '0;
    endcase
  end

  assert_route_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route_q));

  assert_routed_not_arb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((arb_pend & route_q) != '0) |-> $past(route_en));

  assert_masked_no_fiq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((route_q & mask_q) == route_q) |-> !fiq_o);

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  localparam logic [31:0] LVL = 32'h9080_8030;
  localparam logic [31:0] RSV = 32'h0100_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] req = '0;
  logic        irq, fiq;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_we    (we),
    .bus_rdata (rdata),
    .irq_req   (req),
    .irq_o     (irq),
    .fiq_o     (fiq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk);
    req = req | m;
    @(negedge clk);
    req = req & ~m;
  endtask

  task automatic clear_both(input logic [31:0] m);
    wr(8'h00, m);
    wr(8'h10, m);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h08, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R1 src", v, 0);
    rd(8'h10, v); check("R1 arb", v, 0);
    rd(8'h04, v); check("R1 route", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 fiq", {31'b0, fiq}, 0);

    // sweep over every source alone: R2 R3 R4 R7 R8 R5
    for (int i = 0; i < 32; i++) begin
      logic [31:0] bit_i;
      logic        rsv;
      bit_i = 32'h1 << i;
      rsv   = RSV[i];
      wr(8'h08, ~bit_i);
      pulse(bit_i);
      idle(1);
      rd(8'h00, v); check(rsv ? "R2 src" : (LVL[i] ? "R4 src" : "R3 src"), v, rsv ? 0 : bit_i);
      rd(8'h10, v); check("R7 arb", v, rsv ? 0 : bit_i);
      rd(8'h14, v); check("R8 idx", v, rsv ? 0 : i);
      check("R8 irq", {31'b0, irq}, rsv ? 0 : 1);
      clear_both(bit_i);
      idle(1);
      rd(8'h00, v); check("R5 src clr", v, 0);
      rd(8'h10, v); check("R5 arb clr", v, 0);
      check("R8 irq low", {31'b0, irq}, 0);
    end

    // R7 priority with simultaneous requests
    wr(8'h08, 32'h0);
    pulse((32'h1 << 3) | (32'h1 << 9) | (32'h1 << 17));
    idle(1);
    rd(8'h10, v); check("R7 first", v, 32'h1 << 3);
    rd(8'h14, v); check("R8 idx 3", v, 3);
    clear_both(32'h1 << 3);
    idle(1);
    rd(8'h10, v); check("R7 second", v, 32'h1 << 9);
    clear_both(32'h1 << 9);
    idle(1);
    rd(8'h10, v); check("R7 third", v, 32'h1 << 17);
    clear_both(32'h1 << 17);
    idle(1);

    // R7 no reload while occupied
    pulse(32'h1 << 20);
    idle(1);
    pulse(32'h1 << 2);
    idle(1);
    rd(8'h10, v); check("R7 hold", v, 32'h1 << 20);

    // R5 zero writes do nothing
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h00, v); check("R5 src w0", v, (32'h1 << 20) | (32'h1 << 2));
    rd(8'h10, v); check("R5 arb w0", v, 32'h1 << 20);
    clear_both((32'h1 << 20) | (32'h1 << 2));
    idle(2);

    // R6 masked source recorded but not presented
    wr(8'h08, 32'h1 << 12);
    pulse(32'h1 << 12);
    idle(2);
    rd(8'h00, v); check("R6 recorded", v, 32'h1 << 12);
    rd(8'h10, v); check("R6 blocked", v, 0);
    check("R6 irq", {31'b0, irq}, 0);
    wr(8'h08, 32'h0);
    idle(1);
    rd(8'h10, v); check("R6 unmask", v, 32'h1 << 12);
    clear_both(32'h1 << 12);
    idle(1);

    // R4 level source re-sets while held
    @(negedge clk); req[4] = 1'b1;
    idle(2);
    rd(8'h10, v); check("R4 arb", v, 32'h1 << 4);
    wr(8'h00, 32'h1 << 4);
    rd(8'h00, v); check("R4 reset", v, 32'h1 << 4);
    req[4] = 1'b0;
    wr(8'h00, 32'h1 << 4);
    rd(8'h00, v); check("R4 released", v, 0);
    wr(8'h10, 32'h1 << 4);
    idle(1);

    // R3 edge source held high stays cleared
    @(negedge clk); req[10] = 1'b1;
    idle(2);
    wr(8'h00, 32'h1 << 10);
    idle(2);
    rd(8'h00, v); check("R3 no reset", v, 0);
    wr(8'h10, 32'h1 << 10);
    idle(1);
    rd(8'h10, v); check("R3 arb empty", v, 0);
    req[10] = 1'b0;

    // R9 fast routing
    wr(8'h04, 32'h0000_0300);
    rd(8'h04, v); check("R9 lowest kept", v, 32'h0000_0100);
    wr(8'h04, 32'h1 << 11);
    pulse(32'h1 << 11);
    idle(1);
    check("R9 fiq", {31'b0, fiq}, 1);
    check("R9 irq", {31'b0, irq}, 0);
    rd(8'h10, v); check("R9 not arb", v, 0);
    wr(8'h08, 32'h1 << 11);
    check("R6 fiq masked", {31'b0, fiq}, 0);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0);
    check("R9 fiq removed", {31'b0, fiq}, 0);
    idle(1);
    rd(8'h10, v); check("R9 to irq", v, 32'h1 << 11);
    clear_both(32'h1 << 11);
    idle(1);
    check("R8 final irq", {31'b0, irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule